// File: doc/BRIEF.md
# Bus Port Select Decoder

This block watches the address lines and the four active-low bus strobes of an 8-bit processor and turns each bus cycle into a chip-select for at most one of a configurable set of ports. Every port is described by parameters: the address space it lives in (memory or peripheral), whether it is an input port (selected by a read strobe) or an output port (selected by a write strobe), a base address and a compare mask. Mask bits set to one are compared. Mask bits cleared to zero are ignored, so a port with a partial mask answers at every alias of its base address. A full mask gives a single address.

Memory-space ports compare all 16 address lines and respond only to the memory strobes. Peripheral-space ports compare an 8-bit port number and respond only to the I/O strobes. During an I/O cycle the bus repeats the port number on both address bytes, so a parameter picks which byte the decoder reads. An input port and an output port may share one address, and the strobe alone tells them apart. When more than one port matches, the lowest-numbered port wins and a conflict flag is raised. Selects and the flag are registered and appear one clock after the bus state that causes them.

Top module: `io_port_decoder`

## Requirements
- R1: A memory-space port with a full mask is selected only at its exact 16-bit base address. With the default map, a memory write at 0x8000 raises portSel bit 1, and a memory write at 0x8001 or 0xC000 raises no select.
- R2: A peripheral-space port with a full mask is selected only at its exact 8-bit port number. With the default map, I/O write 0x40 raises bit 3, and I/O read 0x41 raises no select.
- R3: Partial masks alias. Port 4 (I/O read, base 0x80, mask 0xF0) is selected for port numbers 0x80 through 0x8F and not for 0x90. Port 5 (memory read, base 0x8000, mask 0xF000) is selected anywhere in 0x8000 to 0x8FFF and not at 0x9000.
- R4: An input port and an output port at the same address are separated by the strobe. At I/O port 0x40, ioRdN low selects bit 2 and ioWrN low selects bit 3.
- R5: Memory strobes never select a peripheral-space port, and I/O strobes never select a memory-space port. Memory read 0x0040 and I/O write 0x8000 both give no select.
- R6: With all four strobes high, portSel is zero and conflict is low, whatever the address.
- R7: The peripheral port number is taken from address bits 7:0 when IO_HALF is 0 (the default) and from bits 15:8 when it is 1. The other byte is ignored: with the default, I/O read at 0x1240 selects bit 2, and at 0x4012 it selects nothing.
- R8: When several ports match, only the lowest-numbered one is selected and conflict is high. Memory read 0x8000 matches ports 0 and 5, giving portSel 0x01 with conflict 1. A single match gives conflict 0.
- R9: Outputs are registered. They change on the first rising clock edge after the inputs change, and reset clears them to zero.
- R10: At most one portSel bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Processor address bus |
| memRdN | input | 1 | Memory read strobe, active low |
| memWrN | input | 1 | Memory write strobe, active low |
| ioRdN | input | 1 | I/O read strobe, active low |
| ioWrN | input | 1 | I/O write strobe, active low |
| portSel | output | NUM_PORTS | One-hot port select, registered |
| conflict | output | 1 | More than one port matched the previous bus state |

## Verification
Every select and the conflict flag are due exactly one rising edge after the address and strobes that cause them. The bench drives each bus state on a falling edge, lets one rising edge pass, and samples at the next falling edge. The latency scenario also samples just before that rising edge, to confirm that the output still shows the earlier idle state. Between scenarios the strobes return high for a cycle, so each result is attributed to the stimulus that produced it.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int ADDR_W = 16;
  localparam int PORTNUM_W = 8;

  // Active-high bus strobes, produced by the control module
  typedef struct packed {
    logic memRd;
    logic memWr;
    logic ioRd;
    logic ioWr;
  } busStrb_t;
endpackage

// File: rtl/io_dec_ctrl.sv
module io_dec_ctrl
  import io_dec_pkg::*;
(
  input  logic     memRdN,
  input  logic     memWrN,
  input  logic     ioRdN,
  input  logic     ioWrN,
  output busStrb_t strb
);
  always_comb begin
    strb.memRd = ~memRdN;
    strb.memWr = ~memWrN;
    strb.ioRd  = ~ioRdN;
    strb.ioWr  = ~ioWrN;
  end
endmodule

// File: rtl/io_dec_match.sv
module io_dec_match
  import io_dec_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int IO_HALF = 0,
  parameter logic [NUM_PORTS-1:0][ADDR_W-1:0] PORT_BASE = '0,
  parameter logic [NUM_PORTS-1:0][ADDR_W-1:0] PORT_MASK = '0,
  parameter logic [NUM_PORTS-1:0] PORT_IO = '0,
  parameter logic [NUM_PORTS-1:0] PORT_WR = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  busStrb_t             strb,
  output logic [NUM_PORTS-1:0] hitVec
);
  logic [PORTNUM_W-1:0] portNum;

  generate
    if (IO_HALF == 0) begin : gLowHalf
      assign portNum = busAddr[PORTNUM_W-1:0];
    end else begin : gHighHalf
      assign portNum = busAddr[ADDR_W-1:ADDR_W-PORTNUM_W];
    end
  endgenerate

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : gPort
      logic qualify;
      logic addrOk;
      if (PORT_IO[i]) begin : gIoSpace
        assign qualify = PORT_WR[i] ? strb.ioWr : strb.ioRd;
        assign addrOk  = ((portNum ^ PORT_BASE[i][PORTNUM_W-1:0])
                          & PORT_MASK[i][PORTNUM_W-1:0]) == '0;
      end else begin : gMemSpace
        assign qualify = PORT_WR[i] ? strb.memWr : strb.memRd;
        assign addrOk  = ((busAddr ^ PORT_BASE[i]) & PORT_MASK[i]) == '0;
      end
      assign hitVec[i] = qualify & addrOk;
    end
  endgenerate

  // R6: no active strobe, no match
  assert_idle_nohit_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.memRd || strb.memWr || strb.ioRd || strb.ioWr) |-> (hitVec == '0));

  // R5: peripheral ports only on I/O strobes, memory ports only on memory strobes
  assert_io_space_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.ioRd || strb.ioWr) |-> ((hitVec & PORT_IO) == '0));
  assert_mem_space_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.memRd || strb.memWr) |-> ((hitVec & ~PORT_IO) == '0));
endmodule

// File: rtl/io_dec_prio.sv
module io_dec_prio #(
  parameter int NUM_PORTS = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] hitVec,
  output logic [NUM_PORTS-1:0] portSel,
  output logic                 conflict
);
  logic [NUM_PORTS-1:0] selNext;
  logic                 found;
  logic                 multiHit;

  always_comb begin
    selNext = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (hitVec[i] && !found) begin
        selNext[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign multiHit = (hitVec & (hitVec - 1'b1)) != '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portSel  <= '0;
      conflict <= 1'b0;
    end else begin
      portSel  <= selNext;
      conflict <= multiHit;
    end
  end

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(portSel));
  assert_conflict_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(hitVec) > 1) |=> conflict);
  assert_no_conflict_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(hitVec) <= 1) |=> !conflict);
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec != '0) |=> (portSel != '0));
  assert_idle_out_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec == '0) |=> (portSel == '0));
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import io_dec_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int IO_HALF = 0,
  // listed from the highest port index down to port 0
  parameter logic [NUM_PORTS-1:0][ADDR_W-1:0] PORT_BASE =
    {16'h8000, 16'h0080, 16'h0040, 16'h0040, 16'h8000, 16'h8000},
  parameter logic [NUM_PORTS-1:0][ADDR_W-1:0] PORT_MASK =
    {16'hF000, 16'h00F0, 16'h00FF, 16'h00FF, 16'hFFFF, 16'hFFFF},
  parameter logic [NUM_PORTS-1:0] PORT_IO = 6'b011100,
  parameter logic [NUM_PORTS-1:0] PORT_WR = 6'b001010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [15:0]          busAddr,
  input  logic                 memRdN,
  input  logic                 memWrN,
  input  logic                 ioRdN,
  input  logic                 ioWrN,
  output logic [NUM_PORTS-1:0] portSel,
  output logic                 conflict
);
  busStrb_t             strb;
  logic [NUM_PORTS-1:0] hitVec;

  io_dec_ctrl u_ctrl (
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .strb(strb)
  );

  io_dec_match #(
    .NUM_PORTS(NUM_PORTS), .IO_HALF(IO_HALF),
    .PORT_BASE(PORT_BASE), .PORT_MASK(PORT_MASK),
    .PORT_IO(PORT_IO), .PORT_WR(PORT_WR)
  ) u_match (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .strb(strb), .hitVec(hitVec)
  );

  io_dec_prio #(.NUM_PORTS(NUM_PORTS)) u_prio (
    .clk(clk), .rstN(rstN), .hitVec(hitVec),
    .portSel(portSel), .conflict(conflict)
  );
endmodule

// File: tb/io_port_decoder_bench.sv
module io_port_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        memRdN = 1'b1, memWrN = 1'b1, ioRdN = 1'b1, ioWrN = 1'b1;
  logic [5:0]  portSel;
  logic        conflict;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  io_port_decoder u_io_port_decoder (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .portSel(portSel), .conflict(conflict)
  );

  task automatic check(string tag, logic [5:0] expSel, logic expConf);
    checks++;
    if (portSel !== expSel || conflict !== expConf) begin
      errors++;
      $display("FAIL %s: portSel=%02h conflict=%0b expected portSel=%02h conflict=%0b",
               tag, portSel, conflict, expSel, expConf);
    end
  endtask

  // kind: 0 idle, 1 memRd, 2 memWr, 3 ioRd, 4 ioWr
  task automatic busCycle(logic [15:0] a, int kind, string tag,
                          logic [5:0] expSel, logic expConf);
    @(negedge clk);
    busAddr = a;
    memRdN = (kind != 1); memWrN = (kind != 2);
    ioRdN  = (kind != 3); ioWrN  = (kind != 4);
    @(negedge clk);
    check(tag, expSel, expConf);
    memRdN = 1'b1; memWrN = 1'b1; ioRdN = 1'b1; ioWrN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R9 reset", 6'h00, 1'b0);
  endtask

  task automatic testIdle();
    busCycle(16'h8000, 0, "R6 idle at 0x8000", 6'h00, 1'b0);
    busCycle(16'h0040, 0, "R6 idle at 0x0040", 6'h00, 1'b0);
  endtask

  task automatic testMemFull();
    busCycle(16'h8000, 2, "R1 memWr 0x8000", 6'h02, 1'b0);
    busCycle(16'h8001, 2, "R1 memWr 0x8001", 6'h00, 1'b0);
    busCycle(16'hC000, 2, "R1 memWr 0xC000", 6'h00, 1'b0);
  endtask

  task automatic testIoFull();
    busCycle(16'h0040, 4, "R2 ioWr 0x40", 6'h08, 1'b0);
    busCycle(16'h0041, 3, "R2 ioRd 0x41", 6'h00, 1'b0);
  endtask

  task automatic testShared();
    busCycle(16'h0040, 3, "R4 ioRd 0x40", 6'h04, 1'b0);
    busCycle(16'h0040, 4, "R4 ioWr 0x40", 6'h08, 1'b0);
  endtask

  task automatic testAlias();
    busCycle(16'h0080, 3, "R3 ioRd 0x80", 6'h10, 1'b0);
    busCycle(16'h0085, 3, "R3 ioRd 0x85", 6'h10, 1'b0);
    busCycle(16'h008F, 3, "R3 ioRd 0x8F", 6'h10, 1'b0);
    busCycle(16'h0090, 3, "R3 ioRd 0x90", 6'h00, 1'b0);
    busCycle(16'h8ABC, 1, "R3 memRd 0x8ABC", 6'h20, 1'b0);
    busCycle(16'h8FFF, 1, "R3 memRd 0x8FFF", 6'h20, 1'b0);
    busCycle(16'h9000, 1, "R3 memRd 0x9000", 6'h00, 1'b0);
  endtask

  task automatic testSpace();
    busCycle(16'h0040, 1, "R5 memRd 0x0040", 6'h00, 1'b0);
    busCycle(16'h8000, 4, "R5 ioWr 0x8000", 6'h00, 1'b0);
    busCycle(16'h0085, 2, "R5 memWr 0x0085", 6'h00, 1'b0);
  endtask

  task automatic testHalf();
    busCycle(16'h1240, 3, "R7 ioRd 0x1240", 6'h04, 1'b0);
    busCycle(16'h4012, 3, "R7 ioRd 0x4012", 6'h00, 1'b0);
  endtask

  task automatic testPriority();
    busCycle(16'h8000, 1, "R8 memRd 0x8000 overlap", 6'h01, 1'b1);
    busCycle(16'h8001, 1, "R8 memRd 0x8001 single", 6'h20, 1'b0);
    busCycle(16'h8000, 0, "R8 conflict clears", 6'h00, 1'b0);
  endtask

  task automatic testLatency();
    @(negedge clk);
    busAddr = 16'h0040; ioRdN = 1'b0;
    #2 check("R9 before edge", 6'h00, 1'b0);
    @(negedge clk);
    check("R9 after edge", 6'h04, 1'b0);
    ioRdN = 1'b1;
    #2 check("R9 held until edge", 6'h04, 1'b0);
    @(negedge clk);
    check("R9 cleared", 6'h00, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testIdle();
    testMemFull();
    testIoFull();
    testShared();
    testAlias();
    testSpace();
    testHalf();
    testPriority();
    testLatency();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule